// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block serves one active-low external interrupt pin on a small 8-bit microcontroller. The pin first passes through a two-flop synchronizer. A falling edge, found by comparing the synchronized value with its previous sample, sets a request latch. In level mode a low level on the synchronized pin also sets the latch.

The latch drives the interrupt line to the CPU through a mask. The mask only gates that output. It never stops the latch from capturing a request, so a request taken while masked is delivered once the mask is cleared.

Software reaches the block over a simple peripheral bus. A status/control register reports the pending flag and holds the mask and trigger-mode bits. It also takes a write-one acknowledge strobe. A second register holds the bit that disconnects the pin pull-up. That bit drives an output and does nothing else. Read data is registered and appears one clock after the address is presented.

Top module: `extint_ctrl`

## Requirements
- R1: After a synchronous reset, `irq_o` is 0 and `pu_dis_o` is 0. The register at 0x1D reads 0x00, so pending, mask and mode are all 0 and the trigger is edge-only.
- R2: The register at 0x1D has this layout: bit 3 is the pending flag (read-only), bit 2 is the acknowledge (always reads 0), bit 1 is the mask and bit 0 is the mode. Bits 7..4 read 0. Any address other than 0x1D and 0x1E reads 0x00. `rdata_o` shows the register selected by `addr_i` on the previous clock.
- R3: A falling edge on `pin_n_i`, seen after the two-flop synchronizer, sets the pending flag. In edge mode (mode=0) a pin that stays low does not set the flag again once it has been acknowledged.
- R4: A write to 0x1D with bit 2 set clears the pending flag. A write with bit 2 clear leaves the flag unchanged.
- R5: `irq_o` is 1 exactly when the pending flag is 1 and the mask is 0. Setting the mask blocks `irq_o` but does not stop the pending flag from being set.
- R6: In level mode (mode=1) a synchronized low pin sets the pending flag. The flag comes back one clock after an acknowledge while the pin is still low.
- R7: If an acknowledge write and a new set condition (edge or level) happen in the same clock, the pending flag stays 1.
- R8: The pull-up disconnect bit is bit 0 at address 0x1E. It can be read and written, drives `pu_dis_o`, and has no other effect. Bits 7..1 at 0x1E read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_n_i | input | 1 | Asynchronous active-low interrupt pin |
| addr_i | input | 8 | Peripheral bus address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request to the CPU |
| pu_dis_o | output | 1 | Pull-up disconnect control |

## Verification
The pin is driven with isolated pulses, with long low holds, and with random toggling. This separates edge capture from level capture, and shows whether a held low retriggers after an acknowledge in each mode. Acknowledge writes are placed in the same clock as a fresh edge and also clear of any edge, which exposes the wrong priority between clearing and setting. Random writes to both register addresses, to unused addresses, and with the acknowledge bit both set and clear show that the mask gates only the output, that reserved bits and unused addresses read zero, and that a write without the acknowledge leaves the flag alone.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int BIT_PND = 3;
  localparam int BIT_ACK = 2;
  localparam int BIT_MSK = 1;
  localparam int BIT_MOD = 0;
  localparam int BIT_PUD = 0;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/extint_detect.sv
module extint_detect (
  input  logic clk,
  input  logic rst,
  input  logic pin_s_i,
  input  logic mode_i,
  input  logic ack_i,
  output logic fall_o,
  output logic set_o,
  output logic pend_o
);
  logic prev_q;
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= pin_s_i;
  end

  assign fall_o = prev_q & ~pin_s_i;
  assign set_o  = fall_o | (mode_i & ~pin_s_i);

  always_ff @(posedge clk) begin
    if (rst)        pend_q <= 1'b0;
    else if (set_o) pend_q <= 1'b1;
    else if (ack_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h1D,
  parameter logic [ADDR_W-1:0] PUD_ADDR = 8'h1E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pend_i,
  output logic              mask_o,
  output logic              mode_o,
  output logic              pud_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              csr_sel, pud_sel;
  logic              mask_q, mode_q, pud_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rd_q;

  assign csr_sel = (addr_i == CSR_ADDR);
  assign pud_sel = (addr_i == PUD_ADDR);
  assign ack_o   = we_i & csr_sel & wdata_i[BIT_ACK];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b0;
      mode_q <= 1'b0;
      pud_q  <= 1'b0;
    end else if (we_i) begin
      if (csr_sel) begin
        mask_q <= wdata_i[BIT_MSK];
        mode_q <= wdata_i[BIT_MOD];
      end
      if (pud_sel) pud_q <= wdata_i[BIT_PUD];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (csr_sel) begin
      rd_mux[BIT_PND] = pend_i;
      rd_mux[BIT_MSK] = mask_q;
      rd_mux[BIT_MOD] = mode_q;
    end else if (pud_sel) begin
      rd_mux[BIT_PUD] = pud_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_mux;
  end

  assign mask_o  = mask_q;
  assign mode_o  = mode_q;
  assign pud_o   = pud_q;
  assign rdata_o = rd_q;
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CSR_ADDR    = 8'h1D,
  parameter logic [ADDR_W-1:0] PUD_ADDR    = 8'h1E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              pu_dis_o
);
  logic pin_s;
  logic fall, set_evt, pend;
  logic mask, mode, pud, ack;

  extint_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk), .rst (rst), .d_i (pin_n_i), .q_o (pin_s)
  );

  extint_detect u_det (
    .clk (clk), .rst (rst), .pin_s_i (pin_s), .mode_i (mode), .ack_i (ack),
    .fall_o (fall), .set_o (set_evt), .pend_o (pend)
  );

  extint_regs #(.CSR_ADDR(CSR_ADDR), .PUD_ADDR(PUD_ADDR)) u_regs (
    .clk (clk), .rst (rst), .addr_i (addr_i), .we_i (we_i), .wdata_i (wdata_i),
    .pend_i (pend), .mask_o (mask), .mode_o (mode), .pud_o (pud), .ack_o (ack),
    .rdata_o (rdata_o)
  );

  assign irq_o    = pend & ~mask;
  assign pu_dis_o = pud;
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic fall,
  input logic set_evt,
  input logic pend,
  input logic mask,
  input logic mode,
  input logic pin_s,
  input logic ack,
  input logic irq_o
);
  a_r3_fall_sets: assert property (@(posedge clk) disable iff (rst)
    fall |=> pend);

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack && !set_evt) |=> !pend);

  a_r6_level_sets: assert property (@(posedge clk) disable iff (rst)
    (mode && !pin_s) |=> pend);

  a_r5_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    mask |-> !irq_o);

  a_r7_set_beats_ack: assert property (@(posedge clk) disable iff (rst)
    (ack && set_evt) |=> pend);

  a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!pend && !set_evt) |=> !pend);
endmodule

bind extint_ctrl extint_ctrl_chk u_chk (
  .clk (clk), .rst (rst), .fall (fall), .set_evt (set_evt), .pend (pend),
  .mask (mask), .mode (mode), .pin_s (pin_s), .ack (ack), .irq_o (irq_o)
);

// File: tb/extint_ctrl_tb.sv
module extint_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_n = 1'b1;
  logic [7:0] addr = 8'h00;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, pud;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  extint_ctrl u_dut (
    .clk (clk), .rst (rst), .pin_n_i (pin_n), .addr_i (addr), .we_i (we),
    .wdata_i (wdata), .rdata_o (rdata), .irq_o (irq), .pu_dis_o (pud)
  );

  // reference model built from the requirements
  logic m_s1, m_s2, m_s3, m_pend, m_mask, m_mode, m_pud;
  logic [7:0] m_rd;

  function automatic logic [7:0] exp_read(input logic [7:0] a, input logic p,
                                          input logic mk, input logic md, input logic pu);
    if (a == 8'h1D) return {4'b0, p, 1'b0, mk, md};
    if (a == 8'h1E) return {7'b0, pu};
    return 8'h00;
  endfunction

  function automatic logic next_pend(input logic p, input logic s2, input logic s3,
                                     input logic md, input logic ackw);
    logic set;
    set = (s3 & ~s2) | (md & ~s2);
    if (set) return 1'b1;
    if (ackw) return 1'b0;
    return p;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_s3 <= 1'b1;
      m_pend <= 1'b0; m_mask <= 1'b0; m_mode <= 1'b0; m_pud <= 1'b0;
      m_rd <= 8'h00;
    end else begin
      m_s1 <= pin_n; m_s2 <= m_s1; m_s3 <= m_s2;
      m_pend <= next_pend(m_pend, m_s2, m_s3, m_mode,
                          we && addr == 8'h1D && wdata[2]);
      if (we && addr == 8'h1D) begin
        m_mask <= wdata[1];
        m_mode <= wdata[0];
      end
      if (we && addr == 8'h1E) m_pud <= wdata[0];
      m_rd <= exp_read(addr, m_pend, m_mask, m_mode, m_pud);
    end
  end

  task automatic check(input string t, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", t, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(tag, "irq_o", {7'b0, irq}, {7'b0, m_pend & ~m_mask});
      check(tag, "rdata_o", rdata, m_rd);
      check("R8", "pu_dis_o", {7'b0, pud}, {7'b0, m_pud});
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      we = 1'b0;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_expect(input string t, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    we = 1'b0; addr = a;
    @(negedge clk);
    check(t, "directed read", rdata, exp);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    // R1 reset state (rdata registered under reset)
    check("R1", "irq_o in reset", {7'b0, irq}, 8'h00);
    check("R1", "pu_dis_o in reset", {7'b0, pud}, 8'h00);
    check("R1", "rdata in reset", rdata, 8'h00);
    rst = 1'b0;
    rd_expect("R1", 8'h1D, 8'h00);

    // R2 layout: reserved, unused addresses
    tag = "R2";
    wr(8'h1D, 8'hFF);
    rd_expect("R2", 8'h1D, 8'h03);
    rd_expect("R2", 8'h40, 8'h00);
    wr(8'h1D, 8'h00);

    // R3 edge capture and no retrigger on held low
    tag = "R3";
    @(negedge clk); pin_n = 1'b0;
    idle(4);
    rd_expect("R3", 8'h1D, 8'h08);
    check("R3", "irq after edge", {7'b0, irq}, 8'h01);
    wr(8'h1D, 8'h04);
    idle(3);
    rd_expect("R3", 8'h1D, 8'h00);
    @(negedge clk); pin_n = 1'b1;
    idle(4);

    // R4 write without ack bit keeps flag, then ack clears
    tag = "R4";
    @(negedge clk); pin_n = 1'b0;
    @(negedge clk); pin_n = 1'b1;
    idle(4);
    wr(8'h1D, 8'h00);
    rd_expect("R4", 8'h1D, 8'h08);
    wr(8'h1D, 8'h04);
    rd_expect("R4", 8'h1D, 8'h00);

    // R5 mask blocks output, flag still sets, unmask releases
    tag = "R5";
    wr(8'h1D, 8'h02);
    @(negedge clk); pin_n = 1'b0;
    @(negedge clk); pin_n = 1'b1;
    idle(4);
    check("R5", "irq masked", {7'b0, irq}, 8'h00);
    rd_expect("R5", 8'h1D, 8'h0A);
    wr(8'h1D, 8'h00);
    check("R5", "irq unmasked", {7'b0, irq}, 8'h01);
    wr(8'h1D, 8'h04);

    // R6 level mode keeps re-setting while low
    tag = "R6";
    wr(8'h1D, 8'h01);
    @(negedge clk); pin_n = 1'b0;
    idle(4);
    wr(8'h1D, 8'h05);
    idle(1);
    rd_expect("R6", 8'h1D, 8'h09);
    @(negedge clk); pin_n = 1'b1;
    idle(4);
    wr(8'h1D, 8'h04);
    idle(2);
    rd_expect("R6", 8'h1D, 8'h00);

    // R7 ack in same clock as fresh edge (edge mode)
    tag = "R7";
    wr(8'h1D, 8'h00);
    @(negedge clk); pin_n = 1'b0;
    idle(1);
    @(negedge clk);
    addr = 8'h1D; wdata = 8'h04; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    rd_expect("R7", 8'h1D, 8'h08);
    @(negedge clk); pin_n = 1'b1;
    wr(8'h1D, 8'h04);
    idle(4);

    // R8 pull-up bit
    tag = "R8";
    wr(8'h1E, 8'hFF);
    rd_expect("R8", 8'h1E, 8'h01);
    check("R8", "pu_dis_o set", {7'b0, pud}, 8'h01);
    rd_expect("R8", 8'h1D, 8'h00);
    wr(8'h1E, 8'h00);
    rd_expect("R8", 8'h1E, 8'h00);

    // random mix, model-checked each cycle
    tag = "R3";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) pin_n = ~pin_n;
      we = ($urandom_range(0, 7) == 0);
      case ($urandom_range(0, 3))
        0, 1: addr = 8'h1D;
        2:    addr = 8'h1E;
        default: addr = 8'($urandom_range(0, 255));
      endcase
      wdata = 8'($urandom_range(0, 255));
    end
    @(negedge clk); we = 1'b0;
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule